// File: doc/BRIEF.md
# Dual-Bank Configuration Store Controller

This block keeps two configuration banks in registers and stands in for a small nonvolatile store. Bank A is 96 bits wide. It holds the capacitor-selection field, the gain code, the wake-up bank select, a security bit and a 21-bit user signature. Bank B holds only a second 70-bit capacitor field. A command source issues single-cycle strobes to bulk-erase, program or verify either bank. A program can only set bits, so a one becomes a zero again only through a bulk erase of its bank.

Each erase or program holds `busy_o` for a fixed number of cycles, set by a parameter that stands in for the long write time of a real cell. Any command that arrives during that window is dropped and latches an error flag. A verify returns the bank image one cycle later. The image comes back as zeros and is marked invalid when the security bit is set. It is also marked invalid when bank A is read while bank A selects bank B at wake-up. The live outputs drive the active bank, the gain code and the capacitor word of the active bank. The gain shows the 10x code for as long as an erase runs.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset both banks are zero, `busy_o`, `cmd_error_o`, `rd_valid_o` and `verify_invalid_o` are 0, `rd_image_o` is zero, and the live outputs read bank 0, gain 0 and capacitor word 0.
- R2: Bank A bit positions: capacitor field [69:0], gain code [71:70] (0=1x, 1=2x, 2=5x, 3=10x), wake-up select [72], security [73], signature [94:74]. Bit 95 is reserved and always reads 0.
- R3: A program ORs the write image into the bank and never clears a bit. Bank A takes `wr_image_i` (bit 95 masked off) and bank B takes `wr_image_i[69:0]`.
- R4: A bulk erase clears every bit of the addressed bank in the accepting cycle. The other bank is left unchanged.
- R5: An accepted erase or program raises `busy_o` from the next cycle on, for exactly OP_CYCLES cycles. A verify never raises `busy_o`.
- R6: A command strobe seen while `busy_o` is 1 has no effect on either bank and sets `cmd_error_o`, which stays 1 until reset.
- R7: When several strobes arrive together in an idle cycle, only one executes, chosen in this priority order: erase A, erase B, program A, program B, verify A, verify B. The others are dropped without error.
- R8: An accepted verify pulses `rd_valid_o` for one cycle, one cycle after acceptance. `rd_image_o` holds its value until the next verify. A bank B readback carries the field in [69:0], with bits [95:70] zero.
- R9: While the security bit is 1, a verify of either bank returns a zero image with `verify_invalid_o` = 1.
- R10: A bank A verify with the wake-up select bit at 1 returns a zero image with `verify_invalid_o` = 1. With the bit at 0 the full bank A image is returned with `verify_invalid_o` = 0.
- R11: Only a bank A erase clears the security bit. A bank B erase leaves it set.
- R12: `live_bank_o` equals the stored wake-up select bit. `live_cap_o` is the bank A field when that bit is 0 and the bank B field when it is 1. `live_gain_o` is the stored gain code.
- R13: While an erase keeps `busy_o` high, `live_gain_o` reads 3 (10x). While a program keeps `busy_o` high it reads the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_a_i | input | 1 | Bulk-erase strobe, bank A |
| erase_b_i | input | 1 | Bulk-erase strobe, bank B |
| prog_a_i | input | 1 | Program strobe, bank A |
| prog_b_i | input | 1 | Program strobe, bank B |
| verify_a_i | input | 1 | Verify strobe, bank A |
| verify_b_i | input | 1 | Verify strobe, bank B |
| wr_image_i | input | 96 | Image ORed into a bank on program |
| rd_image_o | output | 96 | Last verify readback image |
| rd_valid_o | output | 1 | One-cycle pulse when a readback lands |
| verify_invalid_o | output | 1 | Last readback was blocked |
| busy_o | output | 1 | Erase or program in progress |
| cmd_error_o | output | 1 | Sticky flag: command arrived while busy |
| live_bank_o | output | 1 | Active bank (0 = A, 1 = B) |
| live_gain_o | output | 2 | Live gain code |
| live_cap_o | output | 70 | Capacitor word of the active bank |

## Verification
The bench builds the block with OP_CYCLES = 4. Each write completes within a few cycles, so it can sweep every gain code against both wake-up select values and count the busy window cycle by cycle. With the window this short, commands issued while busy, simultaneous strobes and the security sequence (set, bank B erase, bank A erase) all fit in a short run. Expected images come from a bank model in the bench that ORs and clears bits independently of the design.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;
  localparam int IMG_W    = 96;
  localparam int CAP_W    = 70;
  localparam int GAIN_W   = 2;
  localparam int SIG_W    = 21;
  localparam int GAIN_LSB = CAP_W;
  localparam int SEL_BIT  = GAIN_LSB + GAIN_W;
  localparam int SEC_BIT  = SEL_BIT + 1;
  localparam int SIG_LSB  = SEC_BIT + 1;
  localparam int USED_W   = SIG_LSB + SIG_W;
  localparam int NCMD     = 6;

  localparam logic [IMG_W-1:0] A_MASK = {{(IMG_W-USED_W){1'b0}}, {USED_W{1'b1}}};
  localparam logic [GAIN_W-1:0] GAIN_ERASE = '1;

  typedef enum logic [2:0] {
    OP_NONE, OP_ERASE_A, OP_ERASE_B, OP_PROG_A, OP_PROG_B, OP_VERIFY_A, OP_VERIFY_B
  } op_e;

  typedef struct packed {
    logic             blocked;
    logic [IMG_W-1:0] img;
  } rdback_t;

  function automatic logic [IMG_W-1:0] merge_bits(input logic [IMG_W-1:0] old_v,
                                                  input logic [IMG_W-1:0] data,
                                                  input logic [IMG_W-1:0] mask);
    return old_v | (data & mask);
  endfunction

  function automatic rdback_t compose_readback(input logic pick_b,
                                               input logic [IMG_W-1:0] a,
                                               input logic [CAP_W-1:0] b);
    rdback_t r;
    r.blocked = a[SEC_BIT] | (~pick_b & a[SEL_BIT]);
    if (r.blocked)   r.img = '0;
    else if (pick_b) r.img = {{(IMG_W-CAP_W){1'b0}}, b};
    else             r.img = a;
    return r;
  endfunction
endpackage

// File: rtl/cfg_cmd_arbiter.sv
module cfg_cmd_arbiter
  import cfgstore_pkg::*;
(
  input  logic [NCMD-1:0] strobes,
  input  logic            busy,
  output op_e             op,
  output logic            accept,
  output logic            reject
);
  op_e pick;

  always_comb begin
    if      (strobes[5]) pick = OP_ERASE_A;
    else if (strobes[4]) pick = OP_ERASE_B;
    else if (strobes[3]) pick = OP_PROG_A;
    else if (strobes[2]) pick = OP_PROG_B;
    else if (strobes[1]) pick = OP_VERIFY_A;
    else if (strobes[0]) pick = OP_VERIFY_B;
    else                 pick = OP_NONE;
  end

  assign op     = busy ? OP_NONE : pick;
  assign accept = !busy && (pick != OP_NONE);
  assign reject = busy && (|strobes);
endmodule

// File: rtl/cfg_op_timer.sv
module cfg_op_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  output logic busy,
  output logic erasing
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     kind_q <= 1'b0;
    else if (start) kind_q <= start_erase;
  end

  assign erasing = busy & kind_q;

  if (CYCLES <= 1) begin : g_single
    always_ff @(posedge clk) begin
      if (!rst_n) busy <= 1'b0;
      else        busy <= start;
    end
  end else begin : g_count
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (start) begin
        busy  <= 1'b1;
        cnt_q <= CNT_W'(CYCLES - 1);
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bank_store.sv
module cfg_bank_store
  import cfgstore_pkg::*;
#(
  parameter int W = IMG_W,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         erase,
  input  logic         prog,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  logic [IMG_W-1:0] merged;

  always_comb merged = merge_bits(IMG_W'(q), IMG_W'(data), IMG_W'(MASK));

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (erase) q <= '0;
    else if (prog)  q <= merged[W-1:0];
  end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfgstore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             pick_b,
  input  logic [IMG_W-1:0] bank_a,
  input  logic [CAP_W-1:0] bank_b,
  output logic [IMG_W-1:0] rd_image,
  output logic             rd_valid,
  output logic             blocked
);
  rdback_t rb;

  always_comb rb = compose_readback(pick_b, bank_a, bank_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_image <= '0;
      rd_valid <= 1'b0;
      blocked  <= 1'b0;
    end else begin
      rd_valid <= fire;
      if (fire) begin
        rd_image <= rb.img;
        blocked  <= rb.blocked;
      end
    end
  end
endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfgstore_pkg::*;
#(
  parameter int OP_CYCLES = 8_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_a_i,
  input  logic              erase_b_i,
  input  logic              prog_a_i,
  input  logic              prog_b_i,
  input  logic              verify_a_i,
  input  logic              verify_b_i,
  input  logic [IMG_W-1:0]  wr_image_i,
  output logic [IMG_W-1:0]  rd_image_o,
  output logic              rd_valid_o,
  output logic              verify_invalid_o,
  output logic              busy_o,
  output logic              cmd_error_o,
  output logic              live_bank_o,
  output logic [GAIN_W-1:0] live_gain_o,
  output logic [CAP_W-1:0]  live_cap_o
);
  op_e              op_sel;
  logic             cmd_accept;
  logic             cmd_reject;
  logic             acc_erase_a, acc_erase_b, acc_prog_a, acc_prog_b;
  logic             acc_verify, acc_verify_b;
  logic             op_start, erasing;
  logic [IMG_W-1:0] bank_a_q;
  logic [CAP_W-1:0] bank_b_q;

  cfg_cmd_arbiter u_arb (
    .strobes ({erase_a_i, erase_b_i, prog_a_i, prog_b_i, verify_a_i, verify_b_i}),
    .busy    (busy_o),
    .op      (op_sel),
    .accept  (cmd_accept),
    .reject  (cmd_reject)
  );

  assign acc_erase_a  = cmd_accept && (op_sel == OP_ERASE_A);
  assign acc_erase_b  = cmd_accept && (op_sel == OP_ERASE_B);
  assign acc_prog_a   = cmd_accept && (op_sel == OP_PROG_A);
  assign acc_prog_b   = cmd_accept && (op_sel == OP_PROG_B);
  assign acc_verify_b = cmd_accept && (op_sel == OP_VERIFY_B);
  assign acc_verify   = acc_verify_b || (cmd_accept && (op_sel == OP_VERIFY_A));
  assign op_start     = acc_erase_a | acc_erase_b | acc_prog_a | acc_prog_b;

  cfg_op_timer #(.CYCLES(OP_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (op_start),
    .start_erase (acc_erase_a | acc_erase_b),
    .busy        (busy_o),
    .erasing     (erasing)
  );

  cfg_bank_store #(.W(IMG_W), .MASK(A_MASK)) u_bank_a (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (acc_erase_a),
    .prog  (acc_prog_a),
    .data  (wr_image_i),
    .q     (bank_a_q)
  );

  cfg_bank_store #(.W(CAP_W), .MASK({CAP_W{1'b1}})) u_bank_b (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (acc_erase_b),
    .prog  (acc_prog_b),
    .data  (wr_image_i[CAP_W-1:0]),
    .q     (bank_b_q)
  );

  cfg_readback u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (acc_verify),
    .pick_b   (acc_verify_b),
    .bank_a   (bank_a_q),
    .bank_b   (bank_b_q),
    .rd_image (rd_image_o),
    .rd_valid (rd_valid_o),
    .blocked  (verify_invalid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          cmd_error_o <= 1'b0;
    else if (cmd_reject) cmd_error_o <= 1'b1;
  end

  assign live_bank_o = bank_a_q[SEL_BIT];
  assign live_gain_o = erasing ? GAIN_ERASE : bank_a_q[GAIN_LSB +: GAIN_W];
  assign live_cap_o  = live_bank_o ? bank_b_q : bank_a_q[CAP_W-1:0];
endmodule

// File: rtl/cfg_store_ctrl_chk.sv
module cfg_store_ctrl_chk
  import cfgstore_pkg::*;
#(
  parameter int OP_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_erase_a,
  input logic              acc_erase_b,
  input logic              acc_verify,
  input logic              cmd_reject,
  input logic [IMG_W-1:0]  bank_a_q,
  input logic              busy,
  input logic              err,
  input logic              rd_valid,
  input logic [IMG_W-1:0]  rd_image,
  input logic              verify_invalid,
  input logic [GAIN_W-1:0] live_gain
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_BITS_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ($past(acc_erase_a) || (($past(bank_a_q) & ~bank_a_q) == '0))); // R3
  AST_ERASE_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
    acc_erase_a |=> (bank_a_q == '0)); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bank_a_q[IMG_W-1] == 1'b0); // R2
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= OP_CYCLES); // R5
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_RDVALID_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    acc_verify |=> rd_valid); // R8
  AST_RDVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_verify |=> !rd_valid); // R8
  AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bank_a_q[SEC_BIT]) |-> (verify_invalid && rd_image == '0)); // R9
  AST_ERASE_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_erase_a || acc_erase_b) |=> (live_gain == GAIN_ERASE)); // R13
endmodule

bind cfg_store_ctrl cfg_store_ctrl_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_erase_a    (acc_erase_a),
  .acc_erase_b    (acc_erase_b),
  .acc_verify     (acc_verify),
  .cmd_reject     (cmd_reject),
  .bank_a_q       (bank_a_q),
  .busy           (busy_o),
  .err            (cmd_error_o),
  .rd_valid       (rd_valid_o),
  .rd_image       (rd_image_o),
  .verify_invalid (verify_invalid_o),
  .live_gain      (live_gain_o)
);

// File: tb/tb_cfg_store_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_store_ctrl;
  localparam int NCYC = 4;
  localparam logic [5:0] S_EA = 6'b100000, S_EB = 6'b010000, S_PA = 6'b001000,
                         S_PB = 6'b000100, S_VA = 6'b000010, S_VB = 6'b000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic erase_a = 0, erase_b = 0, prog_a = 0, prog_b = 0, ver_a = 0, ver_b = 0;
  logic [95:0] wr = '0;
  logic [95:0] rd_image;
  logic rd_valid, vinv, busy, err, live_bank;
  logic [1:0] live_gain;
  logic [69:0] live_cap;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [95:0] ma = '0;
  logic [69:0] mb = '0;

  always #5 clk = ~clk;

  cfg_store_ctrl #(.OP_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n),
    .erase_a_i(erase_a), .erase_b_i(erase_b), .prog_a_i(prog_a), .prog_b_i(prog_b),
    .verify_a_i(ver_a), .verify_b_i(ver_b), .wr_image_i(wr),
    .rd_image_o(rd_image), .rd_valid_o(rd_valid), .verify_invalid_o(vinv),
    .busy_o(busy), .cmd_error_o(err), .live_bank_o(live_bank),
    .live_gain_o(live_gain), .live_cap_o(live_cap)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] pat(input int k);
    logic [31:0] w0, w1, w2;
    w0 = k * 32'h9E3779B9;
    w1 = (k + 7) * 32'h85EBCA6B;
    w2 = ~(k * 32'hC2B2AE35);
    return {w2, w1, w0};
  endfunction

  function automatic logic [95:0] mk_a(input logic [69:0] cap, input logic [1:0] g,
                                       input logic sel, input logic sec, input logic [20:0] sig,
                                       input logic rsv);
    return {rsv, sig, sec, sel, g, cap};
  endfunction

  function automatic void model_apply(input logic [5:0] s, input logic [95:0] img);
    if (s[5])      ma = '0;
    else if (s[4]) mb = '0;
    else if (s[3]) ma = ma | (img & {1'b0, {95{1'b1}}});
    else if (s[2]) mb = mb | img[69:0];
  endfunction

  function automatic logic [96:0] exp_rd(input logic pick_b);
    if (ma[73]) return {1'b1, 96'b0};
    if (!pick_b && ma[72]) return {1'b1, 96'b0};
    if (pick_b) return {1'b0, 26'b0, mb};
    return {1'b0, ma};
  endfunction

  task automatic pulse(input logic [5:0] s, input logic [95:0] img);
    @(negedge clk);
    {erase_a, erase_b, prog_a, prog_b, ver_a, ver_b} = s;
    wr = img;
    @(negedge clk);
    {erase_a, erase_b, prog_a, prog_b, ver_a, ver_b} = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run(input logic [5:0] s, input logic [95:0] img);
    pulse(s, img);
    model_apply(s, img);
    wait_idle();
  endtask

  task automatic verify(input logic pick_b, input string tag);
    logic [96:0] e;
    pulse(pick_b ? S_VB : S_VA, '0);
    e = exp_rd(pick_b);
    chk({tag, " rd_valid"}, 96'(rd_valid), 96'd1);
    chk({tag, " image"}, rd_image, e[95:0]);
    chk({tag, " invalid"}, 96'(vinv), 96'(e[96]));
  endtask

  task automatic check_live(input string tag);
    chk({tag, " R12 bank"}, 96'(live_bank), 96'(ma[72]));
    chk({tag, " R12 gain"}, 96'(live_gain), 96'(ma[71:70]));
    chk({tag, " R12 cap"}, 96'(live_cap), 96'(ma[72] ? mb : ma[69:0]));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [95:0] held, p1, p2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 96'(busy), 96'd0);
    chk("R1 err", 96'(err), 96'd0);
    chk("R1 rd_valid", 96'(rd_valid), 96'd0);
    chk("R1 invalid", 96'(vinv), 96'd0);
    chk("R1 rd_image", rd_image, '0);
    chk("R1 live", {25'b0, live_bank, live_gain, live_cap}, '0);

    // R2 R10 R12 sweep over gain codes and wake-up select
    for (int g = 0; g < 4; g++) begin
      for (int sel = 0; sel < 2; sel++) begin
        run(S_EA, '0);
        run(S_EB, '0);
        run(S_PA, mk_a(pat(g*2+sel)[69:0], 2'(g), sel[0], 1'b0, pat(g+20)[90:70], 1'b1));
        run(S_PB, pat(g*2+sel+40));
        check_live("R12 sweep");
        verify(1'b0, "R10 R2 sweep A");
        chk("R2 reserved bit", 96'(rd_image[95]), 96'd0);
        verify(1'b1, "R8 sweep B");
      end
    end

    // R3 OR-only programming
    run(S_EA, '0);
    p1 = mk_a(pat(3)[69:0], 2'b01, 1'b0, 1'b0, pat(4)[20:0], 1'b0);
    p2 = mk_a(pat(9)[69:0], 2'b10, 1'b0, 1'b0, pat(5)[20:0], 1'b0);
    run(S_PA, p1);
    run(S_PA, p2);
    verify(1'b0, "R3 OR A");
    chk("R3 OR image", rd_image, p1 | p2);
    run(S_PB, pat(11));
    run(S_PB, pat(12));
    verify(1'b1, "R3 OR B");

    // R4 erase one bank leaves the other
    held = {26'b0, mb};
    run(S_EA, '0);
    verify(1'b1, "R4 B kept");
    chk("R4 B kept image", rd_image, held);
    run(S_PA, mk_a(pat(21)[69:0], 2'b01, 1'b0, 1'b0, '0, 1'b0));
    run(S_EB, '0);
    verify(1'b0, "R4 A kept");
    verify(1'b1, "R4 B erased");
    chk("R4 B zero", rd_image, '0);

    // R8 rd_valid pulse and hold
    verify(1'b0, "R8 A");
    held = rd_image;
    @(negedge clk);
    chk("R8 rd_valid drop", 96'(rd_valid), 96'd0);
    chk("R8 image hold", rd_image, held);

    // R5 busy window, verify does not raise busy
    pulse(S_PB, pat(30));
    model_apply(S_PB, pat(30));
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R5 busy length", 96'(n), 96'(NCYC));
    pulse(S_VA, '0);
    chk("R5 verify no busy", 96'(busy), 96'd0);

    // R13 gain forced during erase, stored during program
    run(S_PA, mk_a('0, 2'b01, 1'b0, 1'b0, '0, 1'b0));
    pulse(S_PA, mk_a('0, 2'b00, 1'b0, 1'b0, '0, 1'b0));
    chk("R13 program gain", 96'(live_gain), 96'd1);
    wait_idle();
    pulse(S_EA, '0);
    model_apply(S_EA, '0);
    chk("R13 erase busy", 96'(busy), 96'd1);
    chk("R13 erase gain", 96'(live_gain), 96'd3);
    @(negedge clk);
    chk("R13 erase gain later", 96'(live_gain), 96'd3);
    wait_idle();
    chk("R13 gain after", 96'(live_gain), 96'd0);

    // R7 simultaneous strobes
    run(S_PA, mk_a(pat(50)[69:0], 2'b10, 1'b0, 1'b0, '0, 1'b0));
    run(S_PB, pat(51));
    pulse(S_EB | S_PA | S_VA, pat(52));
    model_apply(S_EB | S_PA | S_VA, pat(52));
    chk("R7 no readback", 96'(rd_valid), 96'd0);
    wait_idle();
    chk("R7 no error", 96'(err), 96'd0);
    verify(1'b1, "R7 B erased");
    verify(1'b0, "R7 A untouched");
    pulse(S_PB | S_VB, pat(53));
    model_apply(S_PB | S_VB, pat(53));
    wait_idle();
    verify(1'b1, "R7 program wins over verify");

    // R6 commands while busy
    held = {26'b0, mb};
    pulse(S_PA, mk_a(pat(60)[69:0], 2'b00, 1'b0, 1'b0, '0, 1'b0));
    model_apply(S_PA, mk_a(pat(60)[69:0], 2'b00, 1'b0, 1'b0, '0, 1'b0));
    pulse(S_EB, '0);
    chk("R6 err set", 96'(err), 96'd1);
    wait_idle();
    verify(1'b1, "R6 B untouched");
    chk("R6 B image", rd_image, held);
    run(S_PB, pat(61));
    chk("R6 err sticky", 96'(err), 96'd1);

    // R9 R11 security
    run(S_PA, mk_a('0, 2'b00, 1'b0, 1'b1, '0, 1'b0));
    verify(1'b0, "R9 A blocked");
    verify(1'b1, "R9 B blocked");
    chk("R9 B zero", rd_image, '0);
    run(S_EB, '0);
    verify(1'b0, "R11 still blocked");
    chk("R11 invalid", 96'(vinv), 96'd1);
    run(S_EA, '0);
    verify(1'b0, "R11 cleared");
    chk("R11 valid again", 96'(vinv), 96'd0);
    check_live("R12 end");

    summary();
  end
endmodule